// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits between a set of interrupt request flags and a small 8-bit processor core. At each instruction boundary it captures the request flags. It masks them with a per-source enable, ranks them by a per-source priority bit and offers the core a single request together with the index of the winning source. The request stays up until the core acknowledges it. The acknowledge is the point at which the core commits to the forced call.

Nesting is tracked in a four-state level register rather than in a stack. The four states are base, low-active, high-from-base and high-over-low. They record which level is in service and also how it was entered, so a return from interrupt lands in the right place. Two of the return paths arm a guard. After such a return, no new request can be raised until one full instruction has run. The block also produces a wake-up signal for idle and power-down modes. While either mode is set, the request output stays silent.

Top module: `irq_nest_arbiter`

## Requirements
- R1: The request flags are captured only in a cycle where `insn_start_i` is high. A flag change between two strobes has no effect on `irq_o` until the next strobe.
- R2: A captured flag takes part only if its `en_i` bit is 1. Every high-priority source (`prio_i` bit 1) beats every low one. Among sources of the same class, the lowest index wins. `vec_o` gives the winner's index and `irq_hi_o` its class.
- R3: In the base level (`level_o` = 2'b00), any qualified request raises `irq_o`. In the low-active level (2'b01), only a high-priority request does.
- R4: In high-from-base (2'b10) and high-over-low (2'b11), `irq_o` stays low whatever is pending.
- R5: On an accepted acknowledge (`irq_o` and `ack_i` high together), the level moves as follows: base with a high request goes to 2'b10, base with a low request goes to 2'b01, and low-active with a high request goes to 2'b11.
- R6: A `reti_i` pulse moves 2'b10 to 2'b00, 2'b11 to 2'b01 and 2'b01 to 2'b00. It also drops any pending request.
- R7: After a return from 2'b01 to 2'b00, or from 2'b11 to 2'b01, no request is raised until two further `insn_start_i` strobes have been seen. The first strobe ends the return instruction and the second ends the one after it.
- R8: A return from 2'b10 to 2'b00 arms no guard. A pending qualified request reappears on `irq_o` two cycles after the `reti_i` pulse.
- R9: While `irq_o` is high and not acknowledged, `vec_o` and `irq_hi_o` hold their values, even if new flags are captured.
- R10: One cycle after an accepted acknowledge, `hwclr_o` carries a single-cycle one-hot pulse at bit `vec_o`. This happens only if that bit is set in `HWCLR_MASK`; otherwise `hwclr_o` stays zero.
- R11: With `idle_i` set and `pdown_i` clear, `wake_o` is the OR of all raw flags and `ext_rst_i`. With both mode bits clear, `wake_o` is 0.
- R12: With `pdown_i` set, `wake_o` is the OR of `ext_rst_i` and those raw flags that are both enabled and marked in `EXT_MASK`.
- R13: While `idle_i` or `pdown_i` is set, `irq_o` is low and `ack_i` has no effect on the level.
- R14: Synchronous reset leaves `irq_o` low, `level_o` at 2'b00, `hwclr_o` zero and no guard armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_i | input | 1 | External reset pin, used only as a wake-up source |
| flags_i | input | NSRC | Raw interrupt request flags |
| en_i | input | NSRC | Per-source enable |
| prio_i | input | NSRC | Per-source priority, 1 = high |
| insn_start_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Core accepts the pending request |
| idle_i | input | 1 | Idle mode bit |
| pdown_i | input | 1 | Power-down mode bit |
| irq_o | output | 1 | Request to the core |
| vec_o | output | VW | Index of the requesting source |
| irq_hi_o | output | 1 | Request is high priority |
| hwclr_o | output | NSRC | One-cycle hardware flag-clear pulse |
| wake_o | output | 1 | Wake-up from idle or power-down |
| level_o | output | 2 | Nesting level: 00 base, 01 low, 10 high-from-base, 11 high-over-low |

## Verification
The bench builds the block with NSRC=4, EXT_MASK=4'b1100 and HWCLR_MASK=4'b0101. At that size, every combination of flags, enables and priorities is small enough to sweep, 4096 triples in all. Each triple is driven from the base level, and the bench checks the winner, its class, the resulting level and the clear pulse against arithmetic expectations. Directed sequences cover the rest. They walk all four levels and both guarded return paths as well as the unguarded one, and they cover the hold-until-acknowledge rule. With one pin source and one internal source in each class, they also test every wake-up combination of the two sleep modes.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        LV_BASE = 2'b00,
        LV_LOW  = 2'b01,
        LV_HFB  = 2'b10,
        LV_HOL  = 2'b11
    } lvl_e;

    // Strobes needed after a guarded return before a request may rise
    localparam int GUARD_STROBES = 2;
    localparam int GUARD_W       = $clog2(GUARD_STROBES + 1);

    typedef struct packed {
        logic valid;
        logic hi;
    } pick_s;

    function automatic lvl_e lvl_on_accept(lvl_e cur, logic hi);
        lvl_e nxt;
        nxt = cur;
        unique case (cur)
            LV_BASE: nxt = hi ? LV_HFB : LV_LOW;
            LV_LOW:  nxt = hi ? LV_HOL : LV_LOW;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic lvl_e lvl_on_reti(lvl_e cur);
        lvl_e nxt;
        unique case (cur)
            LV_HFB:  nxt = LV_BASE;
            LV_HOL:  nxt = LV_LOW;
            LV_LOW:  nxt = LV_BASE;
            default: nxt = LV_BASE;
        endcase
        return nxt;
    endfunction

    function automatic logic reti_arms_guard(lvl_e cur);
        return (cur == LV_LOW) || (cur == LV_HOL);
    endfunction

    function automatic logic lvl_admits(lvl_e cur, logic hi);
        return (cur == LV_BASE) || ((cur == LV_LOW) && hi);
    endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
    parameter int          NSRC     = 8,
    parameter logic [NSRC-1:0] EXT_MASK = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe_i,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            ext_rst_i,
    input  logic            idle_i,
    input  logic            pdown_i,
    output logic [NSRC-1:0] qual_o,
    output logic            wake_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NSRC-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)           snap_q <= '0;
        else if (strobe_i) snap_q <= flags_i;
    end

    assign qual_o = snap_q & en_i;

    // Wake-up works on raw flags: the clock is assumed stopped in sleep
    logic any_raw, any_pin;
    assign any_raw = |flags_i;
    assign any_pin = |(flags_i & en_i & EXT_MASK);

    always_comb begin
        if (pdown_i)     wake_o = any_pin | ext_rst_i;
        else if (idle_i) wake_o = any_raw | ext_rst_i;
        else             wake_o = 1'b0;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC = 8,
    localparam int VW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]        qual_i,
    input  logic [NSRC-1:0]        prio_i,
    output irq_nest_pkg::pick_s    pick_o,
    output logic [VW-1:0]          vec_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NSRC-1:0] hi_req, lo_req;
    logic [VW-1:0]   hi_idx, lo_idx;
    logic            hi_any, lo_any;

    assign hi_req = qual_i & prio_i;
    assign lo_req = qual_i & ~prio_i;

    // Scan from the top down so the lowest index is written last
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_req[i]) hi_idx = VW'(i);
            if (lo_req[i]) lo_idx = VW'(i);
        end
    end

    assign hi_any = |hi_req;
    assign lo_any = |lo_req;

    assign pick_o.valid = hi_any | lo_any;
    assign pick_o.hi    = hi_any;
    assign vec_o        = hi_any ? hi_idx : lo_idx;
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept_i,
    input  logic               accept_hi_i,
    input  logic               reti_i,
    input  logic               strobe_i,
    output irq_nest_pkg::lvl_e lvl_o,
    output logic               guard_clear_o
);
    timeunit 1ns;
    timeprecision 100ps;
    import irq_nest_pkg::*;

    lvl_e               lvl_q;
    logic [GUARD_W-1:0] gcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= LV_BASE;
            gcnt_q <= '0;
        end else if (reti_i) begin
            lvl_q <= lvl_on_reti(lvl_q);
            if (reti_arms_guard(lvl_q))
                gcnt_q <= GUARD_W'(GUARD_STROBES);
            else if (strobe_i && gcnt_q != '0)
                gcnt_q <= gcnt_q - 1'b1;
        end else begin
            if (accept_i)
                lvl_q <= lvl_on_accept(lvl_q, accept_hi_i);
            if (strobe_i && gcnt_q != '0)
                gcnt_q <= gcnt_q - 1'b1;
        end
    end

    assign lvl_o         = lvl_q;
    assign guard_clear_o = (gcnt_q == '0);
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter #(
    parameter int              NSRC       = 8,
    parameter logic [NSRC-1:0] EXT_MASK   = 8'hFF,
    parameter logic [NSRC-1:0] HWCLR_MASK = 8'h0F,
    localparam int             VW         = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_rst_i,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            insn_start_i,
    input  logic            reti_i,
    input  logic            ack_i,
    input  logic            idle_i,
    input  logic            pdown_i,
    output logic            irq_o,
    output logic [VW-1:0]   vec_o,
    output logic            irq_hi_o,
    output logic [NSRC-1:0] hwclr_o,
    output logic            wake_o,
    output logic [1:0]      level_o
);
    timeunit 1ns;
    timeprecision 100ps;
    import irq_nest_pkg::*;

    logic [NSRC-1:0] qual;
    pick_s           pick;
    logic [VW-1:0]   pick_vec;
    lvl_e            lvl;
    logic            guard_clear;

    logic            req_q, hi_q;
    logic [VW-1:0]   vec_q;
    logic [NSRC-1:0] hwclr_q;
    logic            sleep, eligible, accept;

    irq_sampler #(.NSRC(NSRC), .EXT_MASK(EXT_MASK)) u_smp (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (insn_start_i),
        .flags_i   (flags_i),
        .en_i      (en_i),
        .ext_rst_i (ext_rst_i),
        .idle_i    (idle_i),
        .pdown_i   (pdown_i),
        .qual_o    (qual),
        .wake_o    (wake_o)
    );

    irq_pick #(.NSRC(NSRC)) u_pick (
        .qual_i (qual),
        .prio_i (prio_i),
        .pick_o (pick),
        .vec_o  (pick_vec)
    );

    irq_level_fsm u_lvl (
        .clk           (clk),
        .rst           (rst),
        .accept_i      (accept),
        .accept_hi_i   (hi_q),
        .reti_i        (reti_i),
        .strobe_i      (insn_start_i),
        .lvl_o         (lvl),
        .guard_clear_o (guard_clear)
    );

    assign sleep    = idle_i | pdown_i;
    assign eligible = pick.valid & guard_clear & lvl_admits(lvl, pick.hi);
    assign accept   = req_q & ack_i & ~sleep;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            hi_q  <= 1'b0;
            vec_q <= '0;
        end else if (sleep || reti_i || accept) begin
            req_q <= 1'b0;
        end else if (!req_q && eligible) begin
            req_q <= 1'b1;
            hi_q  <= pick.hi;
            vec_q <= pick_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         hwclr_q <= '0;
        else if (accept) hwclr_q <= (NSRC'(1) << vec_q) & HWCLR_MASK;
        else             hwclr_q <= '0;
    end

    assign irq_o    = req_q & ~sleep;
    assign vec_o    = vec_q;
    assign irq_hi_o = hi_q;
    assign hwclr_o  = hwclr_q;
    assign level_o  = lvl;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int NSRC = 8,
    parameter int VW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            reti_i,
    input logic            ack_i,
    input logic            idle_i,
    input logic            pdown_i,
    input logic            irq_o,
    input logic [VW-1:0]   vec_o,
    input logic            irq_hi_o,
    input logic [NSRC-1:0] hwclr_o,
    input logic [1:0]      level_o
);
    timeunit 1ns;
    timeprecision 100ps;

    // R13
    sleep_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_i || pdown_i) |-> !irq_o);

    // R4
    high_level_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (level_o[1] && !reti_i) |=> !irq_o);

    // R5
    base_hi_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_i && level_o == 2'b00 && irq_hi_o) |=> level_o == 2'b10);

    // R5
    low_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_i && level_o == 2'b01) |=> level_o == 2'b11);

    // R6
    hol_return_chk: assert property (@(posedge clk) disable iff (rst)
        (reti_i && level_o == 2'b11) |=> level_o == 2'b01);

    // R7
    low_return_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (reti_i && level_o == 2'b01) |=> !irq_o ##1 !irq_o);

    // R9
    held_request_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_i && !reti_i) |=> ($stable(vec_o) && $stable(irq_hi_o)));

    // R10
    clear_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hwclr_o));
endmodule

bind irq_nest_arbiter irq_nest_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reti_i   (reti_i),
    .ack_i    (ack_i),
    .idle_i   (idle_i),
    .pdown_i  (pdown_i),
    .irq_o    (irq_o),
    .vec_o    (vec_o),
    .irq_hi_o (irq_hi_o),
    .hwclr_o  (hwclr_o),
    .level_o  (level_o)
);

// File: tb/sim_irq_nest_arbiter.sv
module sim_irq_nest_arbiter;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int         N   = 4;
    localparam logic [3:0] EXT = 4'b1100;
    localparam logic [3:0] HWC = 4'b0101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst = 1'b0;
    logic [3:0] flags = '0, en = '0, prio = '0;
    logic       insn = 1'b0, reti = 1'b0, ack = 1'b0, idle = 1'b0, pdown = 1'b0;
    logic       irq, hi, wake;
    logic [1:0] vec, level;
    logic [3:0] hwclr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_nest_arbiter #(.NSRC(N), .EXT_MASK(EXT), .HWCLR_MASK(HWC)) u0 (
        .clk(clk), .rst(rst), .ext_rst_i(ext_rst), .flags_i(flags), .en_i(en),
        .prio_i(prio), .insn_start_i(insn), .reti_i(reti), .ack_i(ack),
        .idle_i(idle), .pdown_i(pdown), .irq_o(irq), .vec_o(vec),
        .irq_hi_o(hi), .hwclr_o(hwclr), .wake_o(wake), .level_o(level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_insn();
        insn = 1'b1; step(); insn = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    function automatic int lowest(input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R14 reset state
        step(); step();
        chk("R14 irq", irq, 0);
        chk("R14 level", level, 0);
        chk("R14 hwclr", hwclr, 0);
        rst = 1'b0;
        en = 4'b1111;
        step();

        // R1: flags change without strobe is ignored
        pulse_insn();
        flags = 4'b0010;
        step(); step();
        chk("R1 no strobe", irq, 0);
        pulse_insn(); step();
        chk("R1 after strobe irq", irq, 1);
        chk("R1 vec", vec, 1);

        // R5 base low accept, R10 no clear for source 1
        do_ack();
        chk("R5 base->low", level, 2'b01);
        chk("R10 no hw clear", hwclr, 0);

        // R3: low level refuses low requests
        flags = 4'b0011;
        pulse_insn(); step(); step();
        chk("R3 low refused", irq, 0);

        // R3: high accepted in low level
        flags = 4'b1001; prio = 4'b1000;
        pulse_insn(); step();
        chk("R3 high in low irq", irq, 1);
        chk("R3 vec", vec, 3);
        chk("R3 hi", hi, 1);

        // R9: hold while new flags captured
        flags = 4'b0000;
        pulse_insn(); step();
        chk("R9 held irq", irq, 1);
        chk("R9 held vec", vec, 3);
        flags = 4'b1001;
        pulse_insn();
        do_ack();
        chk("R5 low->hol", level, 2'b11);

        // R4: nothing forwarded in high-over-low
        step(); step();
        chk("R4 hol quiet", irq, 0);

        // R6 + R7: return to low, guard
        do_reti();
        chk("R6 hol->low", level, 2'b01);
        step();
        chk("R7 guard 0", irq, 0);
        pulse_insn(); step();
        chk("R7 guard 1", irq, 0);
        pulse_insn(); step();
        chk("R7 guard released", irq, 1);
        chk("R7 vec", vec, 3);

        // back down to base with guard
        do_ack();
        flags = 4'b0000;
        pulse_insn();
        do_reti();
        pulse_insn(); pulse_insn();
        do_reti();
        chk("R6 low->base", level, 2'b00);
        flags = 4'b0001; prio = 4'b0000;
        pulse_insn(); step();
        chk("R7 base guard", irq, 0);
        pulse_insn(); step();
        chk("R7 base released", irq, 1);
        do_ack();
        chk("R10 clear src0", hwclr, 4'b0001);
        step();
        chk("R10 pulse ends", hwclr, 0);
        flags = 4'b0000;
        pulse_insn();
        do_reti();
        pulse_insn(); pulse_insn();

        // R8: high-from-base return has no guard
        flags = 4'b0100; prio = 4'b0100;
        pulse_insn(); step();
        chk("R2 hi irq", irq, 1);
        chk("R2 hi vec", vec, 2);
        do_ack();
        chk("R5 base->hfb", level, 2'b10);
        chk("R10 clear src2", hwclr, 4'b0100);
        step();
        chk("R4 hfb quiet", irq, 0);
        do_reti();
        chk("R6 hfb->base", level, 2'b00);
        step();
        chk("R8 no guard", irq, 1);

        // R13 sleep mutes requests and acknowledges
        idle = 1'b1; #1;
        chk("R13 idle mute", irq, 0);
        do_ack();
        chk("R13 ack ignored", level, 2'b00);
        chk("R13 still muted", irq, 0);

        // R11 idle wake
        flags = 4'b0000; ext_rst = 1'b0; #1;
        chk("R11 idle no wake", wake, 0);
        flags = 4'b0001; #1;
        chk("R11 idle flag wake", wake, 1);
        flags = 4'b0000; ext_rst = 1'b1; #1;
        chk("R11 idle rst wake", wake, 1);

        // R12 power-down wake
        idle = 1'b0; pdown = 1'b1; ext_rst = 1'b0;
        flags = 4'b0001; en = 4'b1111; #1;
        chk("R12 internal ignored", wake, 0);
        flags = 4'b0100; en = 4'b0000; #1;
        chk("R12 disabled pin", wake, 0);
        en = 4'b0100; #1;
        chk("R12 pin wake", wake, 1);
        flags = 4'b0000; ext_rst = 1'b1; #1;
        chk("R12 rst wake", wake, 1);
        pdown = 1'b0; ext_rst = 1'b0; flags = 4'b0101; #1;
        chk("R11 awake no wake", wake, 0);

        // clean up: take the re-raised request and return
        en = 4'b1111;
        step(); step();
        if (irq) do_ack();
        flags = 4'b0000;
        pulse_insn();
        if (level != 2'b00) do_reti();
        pulse_insn(); pulse_insn();
        chk("R6 clean base", level, 2'b00);

        // R2/R5/R10 exhaustive sweep from base
        for (int f = 0; f < 16; f++) begin
            for (int e = 0; e < 16; e++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [3:0] q, ph;
                    int         wv;
                    logic       wh;
                    q  = 4'(f) & 4'(e);
                    ph = q & 4'(p);
                    wh = (ph != 0);
                    wv = wh ? lowest(ph) : lowest(q);
                    flags = 4'(f); en = 4'(e); prio = 4'(p);
                    pulse_insn(); step();
                    if (q == 0) begin
                        chk("R2 none", irq, 0);
                    end else begin
                        chk("R2 irq", irq, 1);
                        chk("R2 vec", vec, wv);
                        chk("R2 hi", hi, wh);
                        do_ack();
                        chk("R5 level", level, wh ? 2'b10 : 2'b01);
                        chk("R10 clear", hwclr, (4'b0001 << wv) & HWC);
                        flags = 4'b0000;
                        pulse_insn();
                        do_reti();
                        pulse_insn(); pulse_insn();
                    end
                end
            end
        end
        flags = 4'b0000;
        step();
        finish_run();
    end
endmodule